// File: doc/BRIEF.md
# Entropy Seed Register Unit

This unit serves a processor's entropy-seed control/status register at CSR address 0x015. The CSR pipeline presents one access per cycle: the address, whether the instruction is a genuine read-write form, the current privilege level, a virtualization flag and the user and supervisor seed-enable bits of the machine security configuration register (bit 8 for user mode, bit 9 for supervisor mode). In the same cycle the unit reports exactly one outcome (no exception, illegal instruction or virtual instruction) and, on a permitted access, returns a 32-bit status word.

A permitted access pulls a 16-bit sample from an entropy source over a valid/ready stream. The unit raises `ent_ready` only in a cycle with a permitted access, so a sample transfers exactly when `ent_valid` and `ent_ready` are both high. The source may hold `ent_valid` low for as long as it likes; the unit never waits and instead answers with the wait status. A failure flag from the source moves the unit into a dead state that lasts until reset, so software is told to stop polling and does not spin on wait.

The status field sits in bits 31:30: 00 self test, 01 wait, 10 sixteen fresh bits present, 11 dead. Data written to the register is discarded.

Top module: `seed_csr_unit`

## Requirements
- R1: An access is seen only when `req_valid` is 1 and `req_addr` equals 0x015; otherwise all three outcome outputs, `rsp_data` and `ent_ready` are 0.
- R2: When `feat_en` is 0, every seen access yields the illegal-instruction outcome.
- R3: A read-only form (`req_rw` = 0) yields the illegal-instruction outcome at every privilege level, virtualized or not.
- R4: With the feature enabled and `req_rw` = 1, machine mode (`priv` = 2'b11) is always permitted, regardless of `virt` and the enable bits.
- R5: From a virtualized non-machine level, the outcome is virtual-instruction when `cfg_sseed` is 1 and illegal-instruction when it is 0.
- R6: Non-virtualized, supervisor (`priv` = 2'b01) is permitted only when `cfg_sseed` is 1, user (`priv` = 2'b00) only when `cfg_useed` is 1; the reserved level 2'b10 and all other cases yield illegal-instruction.
- R7: For a seen access exactly one outcome output is 1, in the same cycle as the request; `ent_ready` is 1 only when the outcome is no exception, and `rsp_data` is 0 on any exception.
- R8: A permitted access with `ent_valid` = 1 and no failure returns `{2'b10, 14'b0, ent_data}` and consumes that sample.
- R9: A permitted access with `ent_valid` = 0 returns the wait word 0x4000_0000.
- R10: A permitted access with `ent_fail` = 1 returns 0xC000_0000; every later permitted access returns the same word with `ent_ready` held at 0 until reset.
- R11: `req_wdata` has no effect, and bits 29:16 of `rsp_data` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Entropy-seed feature present |
| req_valid | input | 1 | CSR access request this cycle |
| req_addr | input | 12 | CSR address |
| req_rw | input | 1 | 1 = read-write form, 0 = read-only form |
| req_wdata | input | 32 | Write operand (discarded) |
| priv | input | 2 | Privilege: 00 user, 01 supervisor, 11 machine |
| virt | input | 1 | Virtualization active |
| cfg_useed | input | 1 | User-mode seed enable |
| cfg_sseed | input | 1 | Supervisor-mode seed enable |
| exc_none | output | 1 | Access permitted |
| exc_illegal | output | 1 | Illegal-instruction exception |
| exc_virtual | output | 1 | Virtual-instruction exception |
| rsp_data | output | 32 | Status word read |
| ent_valid | input | 1 | Entropy sample available |
| ent_ready | output | 1 | Sample taken this cycle |
| ent_data | input | 16 | Entropy sample |
| ent_fail | input | 1 | Entropy source failure |

## Verification
The hardest state to reach is the sticky dead condition followed by further accesses. It needs a permitted access that coincides with a failure, then more permitted accesses that offer clean samples, which must still be refused. Random stimulus keeps failures rare, so runs in the normal states last long, and the bench resets at random points once dead. A directed sequence forces fail-then-valid back to back and then resets to show recovery.

// File: rtl/seed_pkg.sv
package seed_pkg;
  typedef enum logic [1:0] {
    ST_SELFTEST = 2'b00,
    ST_WAIT     = 2'b01,
    ST_FRESH    = 2'b10,
    ST_DEAD     = 2'b11
  } seed_stat_e;

  typedef enum logic [1:0] {
    LVL_USER = 2'b00,
    LVL_SUP  = 2'b01,
    LVL_RSVD = 2'b10,
    LVL_MACH = 2'b11
  } priv_lvl_e;

  typedef struct packed {
    logic none;
    logic illegal;
    logic virt;
  } outcome_t;
endpackage

// File: rtl/seed_access_check.sv
module seed_access_check
  import seed_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       feat_en,
  input  logic       rw_form,
  input  logic [1:0] lvl,
  input  logic       virt,
  input  logic       useed,
  input  logic       sseed,
  output outcome_t   res
);
  logic lvl_mach, lvl_sup, lvl_user;
  assign lvl_mach = (lvl == LVL_MACH);
  assign lvl_sup  = (lvl == LVL_SUP);
  assign lvl_user = (lvl == LVL_USER);

  always_comb begin
    res = '0;
    if (hit) begin
      if (!feat_en || !rw_form) begin
        res.illegal = 1'b1;
      end else if (lvl_mach) begin
        res.none = 1'b1;
      end else if (virt) begin
        if (sseed) res.virt    = 1'b1;
        else       res.illegal = 1'b1;
      end else if ((lvl_sup && sseed) || (lvl_user && useed)) begin
        res.none = 1'b1;
      end else begin
        res.illegal = 1'b1;
      end
    end
  end

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $countones(res) == 1);
  assert_quiet_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> res == '0);
  assert_ro_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rw_form) |-> res.illegal);
  assert_mach_allowed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && feat_en && rw_form && lvl_mach) |-> res.none);
  assert_virt_only_sseed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res.virt |-> (virt && sseed && !lvl_mach));
endmodule

// File: rtl/seed_word_fmt.sv
module seed_word_fmt
  import seed_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant,
  input  logic                ent_valid,
  input  logic [SAMPLE_W-1:0] ent_data,
  input  logic                ent_fail,
  output logic                ent_ready,
  output logic [DATA_W-1:0]   word
);
  localparam int PAD_W = DATA_W - 2 - SAMPLE_W;
  localparam int LOW_W = DATA_W - 2;

  logic dead_q;
  logic dead_now;

  assign dead_now  = dead_q | ent_fail;
  assign ent_ready = grant & ~dead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dead_q <= 1'b0;
    else if (grant && ent_fail) dead_q <= 1'b1;
  end

  always_comb begin
    word = '0;
    if (grant) begin
      if (dead_now)       word = {ST_DEAD, {LOW_W{1'b0}}};
      else if (ent_valid) word = {ST_FRESH, {PAD_W{1'b0}}, ent_data};
      else                word = {ST_WAIT, {LOW_W{1'b0}}};
    end
  end

  assert_dead_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |=> dead_q);
  assert_dead_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && dead_q) |-> (!ent_ready && word[DATA_W-1 -: 2] == ST_DEAD));
  assert_pad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    word[DATA_W-3:SAMPLE_W] == '0);
  assert_no_grant_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> (word == '0 && !ent_ready));
endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit
  import seed_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          SAMPLE_W  = 16,
  parameter logic [11:0] SEED_ADDR = 12'h015
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                feat_en,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_rw,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [1:0]          priv,
  input  logic                virt,
  input  logic                cfg_useed,
  input  logic                cfg_sseed,
  output logic                exc_none,
  output logic                exc_illegal,
  output logic                exc_virtual,
  output logic [DATA_W-1:0]   rsp_data,
  input  logic                ent_valid,
  output logic                ent_ready,
  input  logic [SAMPLE_W-1:0] ent_data,
  input  logic                ent_fail
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SEED_ADDR);

  logic     hit;
  outcome_t res;
  logic     unused_wdata;

  assign hit          = req_valid && (req_addr == MATCH);
  assign unused_wdata = ^req_wdata;

  seed_access_check u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .feat_en (feat_en),
    .rw_form (req_rw),
    .lvl     (priv),
    .virt    (virt),
    .useed   (cfg_useed),
    .sseed   (cfg_sseed),
    .res     (res)
  );

  seed_word_fmt #(
    .DATA_W   (DATA_W),
    .SAMPLE_W (SAMPLE_W)
  ) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (res.none),
    .ent_valid (ent_valid),
    .ent_data  (ent_data),
    .ent_fail  (ent_fail),
    .ent_ready (ent_ready),
    .word      (rsp_data)
  );

  assign exc_none    = res.none;
  assign exc_illegal = res.illegal;
  assign exc_virtual = res.virt;

  assert_ready_needs_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> (hit && exc_none));
  assert_exc_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_illegal || exc_virtual) |-> rsp_data == '0);
endmodule

// File: tb/test_seed_csr_unit.sv
`timescale 1ns/1ps
module test_seed_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        feat_en = 1'b0, req_valid = 1'b0, req_rw = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  priv = '0;
  logic        virt = 1'b0, cfg_useed = 1'b0, cfg_sseed = 1'b0;
  logic        exc_none, exc_illegal, exc_virtual, ent_ready;
  logic [31:0] rsp_data;
  logic        ent_valid = 1'b0, ent_fail = 1'b0;
  logic [15:0] ent_data = '0;

  int checks = 0;
  int errors = 0;
  bit dead_m = 1'b0;

  always #2 clk = ~clk;

  seed_csr_unit i_seed_csr_unit (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_rw(req_rw), .req_wdata(req_wdata), .priv(priv),
    .virt(virt), .cfg_useed(cfg_useed), .cfg_sseed(cfg_sseed),
    .exc_none(exc_none), .exc_illegal(exc_illegal), .exc_virtual(exc_virtual),
    .rsp_data(rsp_data), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_data(ent_data), .ent_fail(ent_fail)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {none, illegal, virt}
  function automatic logic [2:0] exp_out(bit hit, bit fe, bit rw, logic [1:0] p, bit v, bit u, bit s);
    if (!hit) return 3'b000;
    if (!fe || !rw) return 3'b010;
    if (p == 2'b11) return 3'b100;
    if (v) return s ? 3'b001 : 3'b010;
    if (p == 2'b01 && s) return 3'b100;
    if (p == 2'b00 && u) return 3'b100;
    return 3'b010;
  endfunction

  function automatic string out_tag(bit hit, bit fe, bit rw, logic [1:0] p, bit v);
    if (!hit) return "R1";
    if (!fe) return "R2";
    if (!rw) return "R3";
    if (p == 2'b11) return "R4";
    if (v) return "R5";
    return "R6";
  endfunction

  function automatic logic [31:0] exp_word(bit perm, bit dead, bit fail, bit val, logic [15:0] d);
    if (!perm) return 32'h0;
    if (dead || fail) return 32'hC000_0000;
    if (val) return {2'b10, 14'b0, d};
    return 32'h4000_0000;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    dead_m = 1'b0;
  endtask

  task automatic step(input bit rv, input logic [11:0] a, input bit fe, input bit rw,
                      input logic [1:0] p, input bit v, input bit u, input bit s,
                      input bit ev, input bit ef, input logic [15:0] d, input logic [31:0] wd);
    logic [2:0]  eo;
    logic [31:0] ew;
    bit          hit, perm;
    string       tg;
    @(negedge clk);
    req_valid = rv; req_addr = a; feat_en = fe; req_rw = rw; priv = p; virt = v;
    cfg_useed = u; cfg_sseed = s; ent_valid = ev; ent_fail = ef; ent_data = d; req_wdata = wd;
    #1;
    hit  = rv && (a == 12'h015);
    eo   = exp_out(hit, fe, rw, p, v, u, s);
    perm = eo[2];
    tg   = out_tag(hit, fe, rw, p, v);
    chk({exc_none, exc_illegal, exc_virtual} == eo, tg,
        {29'b0, exc_none, exc_illegal, exc_virtual}, {29'b0, eo});
    chk(hit ? $countones({exc_none, exc_illegal, exc_virtual}) == 1 : 1'b1, "R7",
        {29'b0, exc_none, exc_illegal, exc_virtual}, {29'b0, eo});
    ew = exp_word(perm, dead_m, ef, ev, d);
    if (!perm) tg = "R7";
    else if (dead_m || ef) tg = "R10";
    else if (ev) tg = "R8";
    else tg = "R9";
    chk(rsp_data == ew, tg, rsp_data, ew);
    chk(rsp_data[29:16] == 14'b0, "R11", rsp_data, ew);
    chk(ent_ready == (perm && !dead_m), dead_m ? "R10" : "R7",
        {31'b0, ent_ready}, {31'b0, perm && !dead_m});
    @(posedge clk);
    if (perm && ef) dead_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    #1;
    chk({exc_none, exc_illegal, exc_virtual, ent_ready} == 4'b0 && rsp_data == 0, "R1",
        {28'b0, exc_none, exc_illegal, exc_virtual, ent_ready}, 32'h0);
    do_reset();

    // directed corners
    step(1, 12'h015, 1, 1, 2'b11, 1, 0, 0, 1, 0, 16'hBEEF, 32'h0);           // R4 machine, virt ignored, R8
    step(1, 12'h016, 1, 1, 2'b11, 0, 1, 1, 1, 0, 16'h1234, 32'h0);           // R1 wrong address
    step(0, 12'h015, 1, 1, 2'b11, 0, 1, 1, 1, 0, 16'h1234, 32'h0);           // R1 no request
    step(1, 12'h015, 0, 1, 2'b11, 0, 1, 1, 1, 0, 16'h1234, 32'h0);           // R2
    step(1, 12'h015, 1, 0, 2'b11, 0, 1, 1, 1, 0, 16'h1234, 32'h0);           // R3 machine read-only
    step(1, 12'h015, 1, 1, 2'b01, 1, 0, 1, 1, 0, 16'h1234, 32'h0);           // R5 virtual
    step(1, 12'h015, 1, 1, 2'b00, 1, 1, 0, 1, 0, 16'h1234, 32'h0);           // R5 illegal
    step(1, 12'h015, 1, 1, 2'b10, 0, 1, 1, 1, 0, 16'h1234, 32'h0);           // R6 reserved level
    step(1, 12'h015, 1, 1, 2'b00, 0, 1, 0, 0, 0, 16'h1234, 32'h0);           // R6 user, R9 wait
    step(1, 12'h015, 1, 1, 2'b01, 0, 0, 1, 1, 0, 16'h0001, 32'hFFFF_FFFF);   // R11 wdata ignored
    step(1, 12'h015, 1, 1, 2'b11, 0, 0, 0, 1, 1, 16'h5555, 32'h0);           // R10 fail
    step(1, 12'h015, 1, 1, 2'b11, 0, 0, 0, 1, 0, 16'h5555, 32'h0);           // R10 sticky
    step(1, 12'h015, 1, 1, 2'b01, 0, 0, 1, 1, 0, 16'h7777, 32'h0);           // R10 sticky
    do_reset();
    step(1, 12'h015, 1, 1, 2'b11, 0, 0, 0, 1, 0, 16'hA5A5, 32'h0);           // R10 cleared by reset

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = ($urandom % 8 != 0) ? 12'h015 : 12'($urandom);
      step(($urandom % 10) != 0, a, ($urandom % 10) != 0, ($urandom % 5) != 0,
           2'($urandom), ($urandom % 3) == 0, 1'($urandom), 1'($urandom),
           ($urandom % 10) < 7, ($urandom % 40) == 0, 16'($urandom), $urandom);
      if (dead_m && ($urandom % 6) == 0) do_reset();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule